// File: doc/BRIEF.md
# Per-Register Vector Configuration Lookup and Instruction Classifier

This decode-stage unit decides, for each operand of an instruction, how wide its elements are and how many consecutive registers it spans. A small table of configuration entries is held locally. Each entry names one register, by register number and by bank (integer or floating-point), and carries an element-width code and a vector length. Each operand's register is looked up in this table. When an entry names that register in that bank, the entry's width and length apply. When none does, the operand is treated as a plain scalar of the width the opcode implies.

From the three resolved operands (destination, source 1, source 2), the unit also reports an execution class. The class tells the issue logic whether the instruction can go straight through unchanged, whether it has to be repeated across a vector, whether it has to be narrowed or widened, or whether it needs both. The unit also raises a fault when the operand lengths cannot be combined. The table is written through a simple write port. Lookup and classification are purely combinational.

Top module: `vcfg_decode`

## Requirements
- R1: There are two entries, selected by `cfg_sel` (0 or 1). Each entry holds a bank bit, a 5-bit register number, a 2-bit width code and an 8-bit length. When `cfg_we` is high at a rising clock edge, the selected entry takes the port values and becomes in use. The other entry keeps its contents.
- R2: A synchronous reset (`rst_n` low at a clock edge) marks both entries unused. Afterwards, every operand reads back as length 1 with the width `dflt_width`.
- R3: An operand that no in-use entry matches gets length 1 and width `dflt_width`.
- R4: The entries are searched from index 0 upward. When both entries match an operand, entry 0 supplies the width and the length.
- R5: A match needs both the register number and the bank to be equal, with bank 0 meaning integer and bank 1 meaning floating-point. An entry for integer register N never applies to floating-point register N, and the reverse also holds.
- R6: `op_class` is 0 when all three lengths are 1 and all three widths equal `dflt_width`. It is 1 when some length is above 1 and all widths equal the default. It is 2 when all lengths are 1 and some width differs from the default. It is 3 when some length is above 1 and some width differs.
- R7: `len_fault` is high whenever the two source lengths differ.
- R8: `len_fault` is high when the destination length is above 1 and either source length exceeds it. It stays low when the destination is a scalar and the two sources have equal lengths.
- R9: All outputs follow the operand and default-width inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the entry table |
| cfg_sel | input | 1 | Entry index written |
| cfg_bank | input | 1 | Bank of the register named by the entry (0 integer, 1 floating-point) |
| cfg_reg | input | 5 | Register number named by the entry |
| cfg_width | input | 2 | Element-width code stored in the entry |
| cfg_len | input | 8 | Vector length stored in the entry |
| dflt_width | input | 2 | Width code implied by the opcode |
| rd_bank | input | 1 | Destination bank |
| rd_reg | input | 5 | Destination register number |
| rs1_bank | input | 1 | Source 1 bank |
| rs1_reg | input | 5 | Source 1 register number |
| rs2_bank | input | 1 | Source 2 bank |
| rs2_reg | input | 5 | Source 2 register number |
| rd_width | output | 2 | Resolved destination width |
| rd_len | output | 8 | Resolved destination length |
| rs1_width | output | 2 | Resolved source 1 width |
| rs1_len | output | 8 | Resolved source 1 length |
| rs2_width | output | 2 | Resolved source 2 width |
| rs2_len | output | 8 | Resolved source 2 length |
| op_class | output | 2 | Execution class code |
| len_fault | output | 1 | Illegal length combination |

## Verification
The bench programs both entries with the same register and checks that entry 0 wins; a design that searched from the top would return entry 1's length. It names the same register number in the other bank; a design that ignored the bank would wrongly vectorise that operand. It sets an entry with length 1 but a non-default width to separate class 2 from class 0, which a classifier keyed only on length would merge. It also drives a scalar destination with equal-length vector sources, which must not fault, against a vector destination shorter than its sources, which must fault; a design that compared lengths regardless of the destination being scalar would reject legal reductions.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  parameter int unsigned VC_REG_W = 5;
  parameter int unsigned VC_BW_W  = 2;
  parameter int unsigned VC_LEN_W = 8;

  typedef enum logic [1:0] {
    CLS_PASS     = 2'd0,
    CLS_VEC      = 2'd1,
    CLS_WIDE     = 2'd2,
    CLS_VEC_WIDE = 2'd3
  } vcls_e;

  typedef struct packed {
    logic                used;
    logic                bank;
    logic [VC_REG_W-1:0] regn;
    logic [VC_BW_W-1:0]  width;
    logic [VC_LEN_W-1:0] len;
  } vent_t;

  // entry applies to an operand
  function automatic logic ent_hit(vent_t e, logic bank, logic [VC_REG_W-1:0] r);
    return e.used && (e.bank == bank) && (e.regn == r);
  endfunction

  // operand lengths that cannot be combined
  function automatic logic len_conflict(logic [VC_LEN_W-1:0] d,
                                        logic [VC_LEN_W-1:0] a,
                                        logic [VC_LEN_W-1:0] b);
    logic dvec;
    dvec = (d > VC_LEN_W'(1));
    return (a != b) || (dvec && ((a > d) || (b > d)));
  endfunction

  function automatic vcls_e class_of(logic any_vec, logic any_wide);
    return vcls_e'({any_wide, any_vec});
  endfunction

endpackage

// File: rtl/vcfg_table.sv
module vcfg_table
  import vcfg_pkg::*;
#(
  parameter int unsigned NUM_ENT = 2,
  localparam int unsigned SEL_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  vent_t                    wr_word,
  output vent_t [NUM_ENT-1:0]      ents
);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic sel_me;
    assign sel_me = wr_en && (wr_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (sel_me) begin
        ents[i] <= wr_word;
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(i)) |=> (ents[i] == $past(wr_word))); // R1
    AST_OTHER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel != SEL_W'(i) && $past(rst_n)) |=> $stable(ents[i])); // R1
  end

endmodule

// File: rtl/vcfg_lookup.sv
module vcfg_lookup
  import vcfg_pkg::*;
#(
  parameter int unsigned NUM_ENT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vent_t [NUM_ENT-1:0]  ents,
  input  logic                 op_bank,
  input  logic [VC_REG_W-1:0]  op_reg,
  input  logic [VC_BW_W-1:0]   dflt_w,
  output logic [VC_BW_W-1:0]   res_w,
  output logic [VC_LEN_W-1:0]  res_len,
  output logic                 hit
);

  logic [NUM_ENT-1:0] raw_hits;
  logic [NUM_ENT-1:0] pick;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign raw_hits[i] = ent_hit(ents[i], op_bank, op_reg);
  end

  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < int'(NUM_ENT); i++) begin
      if (raw_hits[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    res_w   = dflt_w;
    res_len = VC_LEN_W'(1);
    for (int i = 0; i < int'(NUM_ENT); i++) begin
      if (pick[i]) begin
        res_w   = ents[i].width;
        res_len = ents[i].len;
      end
    end
  end

  assign hit = |pick;

  AST_MISS_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hits == '0) |-> (res_len == VC_LEN_W'(1) && res_w == dflt_w)); // R3
  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hits[0] |-> (res_len == ents[0].len && res_w == ents[0].width)); // R4
  AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)); // R4
  AST_BANK_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ents[0].bank != op_bank) |-> !pick[0]); // R5

endmodule

// File: rtl/vcfg_classify.sv
module vcfg_classify
  import vcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VC_BW_W-1:0]   dflt_w,
  input  logic [VC_BW_W-1:0]   d_w,
  input  logic [VC_LEN_W-1:0]  d_len,
  input  logic [VC_BW_W-1:0]   a_w,
  input  logic [VC_LEN_W-1:0]  a_len,
  input  logic [VC_BW_W-1:0]   b_w,
  input  logic [VC_LEN_W-1:0]  b_len,
  output vcls_e                cls,
  output logic                 fault
);

  logic any_vec;
  logic any_wide;

  assign any_vec  = (d_len != VC_LEN_W'(1)) || (a_len != VC_LEN_W'(1)) ||
                    (b_len != VC_LEN_W'(1));
  assign any_wide = (d_w != dflt_w) || (a_w != dflt_w) || (b_w != dflt_w);
  assign cls      = class_of(any_vec, any_wide);
  assign fault    = len_conflict(d_len, a_len, b_len);

  AST_SRC_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (a_len != b_len) |-> fault); // R7
  AST_DEST_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_len > 8'd1 && (a_len > d_len || b_len > d_len)) |-> fault); // R8
  AST_REDUCE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (d_len <= 8'd1 && a_len == b_len) |-> !fault); // R8
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_PASS) |-> (d_len == 8'd1 && a_len == 8'd1 && b_len == 8'd1
                           && d_w == dflt_w && a_w == dflt_w && b_w == dflt_w)); // R6

endmodule

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int unsigned NUM_ENT = 2,
  localparam int unsigned SEL_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int unsigned NUM_OPS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                cfg_bank,
  input  logic [VC_REG_W-1:0] cfg_reg,
  input  logic [VC_BW_W-1:0]  cfg_width,
  input  logic [VC_LEN_W-1:0] cfg_len,
  input  logic [VC_BW_W-1:0]  dflt_width,
  input  logic                rd_bank,
  input  logic [VC_REG_W-1:0] rd_reg,
  input  logic                rs1_bank,
  input  logic [VC_REG_W-1:0] rs1_reg,
  input  logic                rs2_bank,
  input  logic [VC_REG_W-1:0] rs2_reg,
  output logic [VC_BW_W-1:0]  rd_width,
  output logic [VC_LEN_W-1:0] rd_len,
  output logic [VC_BW_W-1:0]  rs1_width,
  output logic [VC_LEN_W-1:0] rs1_len,
  output logic [VC_BW_W-1:0]  rs2_width,
  output logic [VC_LEN_W-1:0] rs2_len,
  output logic [1:0]          op_class,
  output logic                len_fault
);

  vent_t [NUM_ENT-1:0] ents;
  vent_t               wr_word;

  logic [NUM_OPS-1:0]               op_bank;
  logic [NUM_OPS-1:0][VC_REG_W-1:0] op_reg;
  logic [NUM_OPS-1:0][VC_BW_W-1:0]  op_w;
  logic [NUM_OPS-1:0][VC_LEN_W-1:0] op_len;
  logic [NUM_OPS-1:0]               op_hit;
  vcls_e                            cls;

  assign wr_word = '{used: 1'b1, bank: cfg_bank, regn: cfg_reg,
                     width: cfg_width, len: cfg_len};

  vcfg_table #(.NUM_ENT(NUM_ENT)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_word (wr_word),
    .ents    (ents)
  );

  assign op_bank = {rs2_bank, rs1_bank, rd_bank};
  assign op_reg  = {rs2_reg, rs1_reg, rd_reg};

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    vcfg_lookup #(.NUM_ENT(NUM_ENT)) u_lookup (
      .clk     (clk),
      .rst_n   (rst_n),
      .ents    (ents),
      .op_bank (op_bank[k]),
      .op_reg  (op_reg[k]),
      .dflt_w  (dflt_width),
      .res_w   (op_w[k]),
      .res_len (op_len[k]),
      .hit     (op_hit[k])
    );
  end

  vcfg_classify u_classify (
    .clk    (clk),
    .rst_n  (rst_n),
    .dflt_w (dflt_width),
    .d_w    (op_w[0]),
    .d_len  (op_len[0]),
    .a_w    (op_w[1]),
    .a_len  (op_len[1]),
    .b_w    (op_w[2]),
    .b_len  (op_len[2]),
    .cls    (cls),
    .fault  (len_fault)
  );

  assign rd_width  = op_w[0];
  assign rd_len    = op_len[0];
  assign rs1_width = op_w[1];
  assign rs1_len   = op_len[1];
  assign rs2_width = op_w[2];
  assign rs2_len   = op_len[2];
  assign op_class  = cls;

  AST_HIT_MEANS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (|op_hit) |-> (ents[0].used || ents[1].used)); // R2

endmodule

// File: tb/test_vcfg_decode.sv
module test_vcfg_decode;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic       cfg_bank = 1'b0;
  logic [4:0] cfg_reg = '0;
  logic [1:0] cfg_width = '0;
  logic [7:0] cfg_len = '0;
  logic [1:0] dflt_width = 2'd3;
  logic       rd_bank = 1'b0, rs1_bank = 1'b0, rs2_bank = 1'b0;
  logic [4:0] rd_reg = '0, rs1_reg = '0, rs2_reg = '0;
  logic [1:0] rd_width, rs1_width, rs2_width, op_class;
  logic [7:0] rd_len, rs1_len, rs2_len;
  logic       len_fault;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model of the table
  bit       m_used [2];
  bit       m_bank [2];
  int       m_reg  [2];
  int       m_w    [2];
  int       m_len  [2];

  always #4 clk = ~clk;

  vcfg_decode i_vcfg_decode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_bank(cfg_bank), .cfg_reg(cfg_reg), .cfg_width(cfg_width),
    .cfg_len(cfg_len), .dflt_width(dflt_width),
    .rd_bank(rd_bank), .rd_reg(rd_reg), .rs1_bank(rs1_bank),
    .rs1_reg(rs1_reg), .rs2_bank(rs2_bank), .rs2_reg(rs2_reg),
    .rd_width(rd_width), .rd_len(rd_len), .rs1_width(rs1_width),
    .rs1_len(rs1_len), .rs2_width(rs2_width), .rs2_len(rs2_len),
    .op_class(op_class), .len_fault(len_fault)
  );

  // walk from the top down, letting lower entries overwrite: first match wins
  task automatic model_look(input bit b, input int r, output int w, output int l);
    w = int'(dflt_width);
    l = 1;
    for (int i = 1; i >= 0; i--) begin
      if (m_used[i] && m_bank[i] == b && m_reg[i] == r) begin
        w = m_w[i];
        l = m_len[i];
      end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare every output against the model
  task automatic check_model(input string req);
    int dw, dl, aw, al, bw, bl, ecls, efl;
    bit vec, wide;
    model_look(rd_bank, int'(rd_reg), dw, dl);
    model_look(rs1_bank, int'(rs1_reg), aw, al);
    model_look(rs2_bank, int'(rs2_reg), bw, bl);
    vec  = (dl != 1) || (al != 1) || (bl != 1);
    wide = (dw != int'(dflt_width)) || (aw != int'(dflt_width)) || (bw != int'(dflt_width));
    ecls = (wide ? 2 : 0) + (vec ? 1 : 0);
    efl  = ((al != bl) || (dl > 1 && (al > dl || bl > dl))) ? 1 : 0;
    check({req, " rd_w"},   int'(rd_width), dw);
    check({req, " rd_len"}, int'(rd_len), dl);
    check({req, " rs1_w"},  int'(rs1_width), aw);
    check({req, " rs1_len"},int'(rs1_len), al);
    check({req, " rs2_w"},  int'(rs2_width), bw);
    check({req, " rs2_len"},int'(rs2_len), bl);
    check({req, " class"},  int'(op_class), ecls);
    check({req, " fault"},  int'(len_fault), efl);
  endtask

  task automatic write_ent(input bit sel, input bit b, input int r, input int w, input int l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_bank = b;
    cfg_reg = 5'(r); cfg_width = 2'(w); cfg_len = 8'(l);
    @(negedge clk);
    cfg_we = 1'b0;
    m_used[sel] = 1'b1; m_bank[sel] = b; m_reg[sel] = r;
    m_w[sel] = w; m_len[sel] = l;
  endtask

  task automatic ops(input bit db, input int dr, input bit ab, input int ar,
                     input bit bb, input int br);
    rd_bank = db; rd_reg = 5'(dr);
    rs1_bank = ab; rs1_reg = 5'(ar);
    rs2_bank = bb; rs2_reg = 5'(br);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_used[0] = 1'b0; m_used[1] = 1'b0;
  endtask

  task automatic t_reset_state();
    ops(0, 3, 0, 3, 1, 3);
    check("R2 len after reset", int'(rd_len), 1);
    check("R2 width after reset", int'(rs1_width), 3);
    check("R2 class after reset", int'(op_class), 0);
    check_model("R2");
  endtask

  task automatic t_write_and_bank();
    write_ent(0, 0, 3, 2, 4);
    ops(0, 3, 0, 3, 0, 3);
    check("R1 written len", int'(rs1_len), 4);
    check("R1 written width", int'(rs1_width), 2);
    check_model("R1");
    ops(1, 3, 1, 3, 1, 3);
    check("R5 fp reg 3 not matched", int'(rs1_len), 1);
    check_model("R5");
    ops(0, 4, 0, 4, 0, 4);
    check("R3 unmatched len", int'(rd_len), 1);
    check("R3 unmatched width", int'(rd_width), 3);
  endtask

  task automatic t_priority();
    write_ent(1, 0, 3, 1, 2);
    ops(0, 3, 0, 3, 0, 3);
    check("R4 entry0 wins len", int'(rs2_len), 4);
    check("R4 entry0 wins width", int'(rs2_width), 2);
    check_model("R4");
    check("R1 entry0 kept", int'(rd_len), 4);
  endtask

  task automatic t_classes();
    // class 1: vector, default width
    write_ent(0, 0, 9, 3, 8);
    write_ent(1, 1, 5, 0, 1);
    ops(0, 9, 0, 9, 0, 9);
    check("R6 class vec", int'(op_class), 1);
    check("R8 equal lengths no fault", int'(len_fault), 0);
    // class 2: scalar, non-default width
    ops(1, 5, 0, 2, 0, 2);
    check("R6 class wide", int'(op_class), 2);
    // class 3
    write_ent(1, 1, 5, 0, 8);
    ops(1, 5, 0, 9, 0, 9);
    check("R6 class vec wide", int'(op_class), 3);
    check_model("R6");
    // class 0
    ops(0, 1, 0, 2, 1, 9);
    check("R6 class pass", int'(op_class), 0);
  endtask

  task automatic t_faults();
    write_ent(0, 0, 9, 3, 8);
    write_ent(1, 0, 6, 3, 4);
    ops(0, 1, 0, 9, 0, 2);
    check("R7 src length mismatch", int'(len_fault), 1);
    ops(0, 6, 0, 9, 0, 9);
    check("R8 dest shorter than src", int'(len_fault), 1);
    ops(0, 1, 0, 9, 0, 9);
    check("R8 scalar dest reduction", int'(len_fault), 0);
    ops(0, 9, 0, 6, 0, 6);
    check("R8 sources shorter than dest", int'(len_fault), 0);
    check_model("R8");
  endtask

  task automatic t_comb();
    @(negedge clk);
    ops(0, 9, 0, 9, 0, 9);
    check("R9 same cycle len", int'(rd_len), 8);
    ops(0, 6, 0, 6, 0, 6);
    check("R9 same cycle change", int'(rd_len), 4);
    dflt_width = 2'd1; #1;
    check("R9 default follows", int'(op_class), 3);
    check_model("R9");
    dflt_width = 2'd3; #1;
  endtask

  task automatic t_reset_clears();
    do_reset();
    ops(0, 9, 0, 6, 0, 6);
    check("R2 cleared len", int'(rs1_len), 1);
    check("R2 cleared fault", int'(len_fault), 0);
    check_model("R2 mid-run");
  endtask

  initial begin
    m_used[0] = 1'b0; m_used[1] = 1'b0;
    do_reset();
    t_reset_state();
    t_write_and_bank();
    t_priority();
    t_classes();
    t_faults();
    t_comb();
    t_reset_clears();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule